// File: doc/BRIEF.md
# Queue error interrupt controller

This block keeps the miscellaneous interrupt state of one work queue. Five sticky cause bits record error and notification events that arrive from neighbouring logic as one-cycle pulses. Software can also raise them through a set alias, and it removes them by writing ones to the cause register. A separate enable bit for each cause gates it onto a single level-sensitive interrupt line.

The block also holds the queue's run/stop bit. When continue-on-error is off, a doorbell overflow, an instruction read error or a result write error stops the queue. Each of these stops it whether the event came from hardware or from software through the set alias. Only a software write starts the queue again. The engine software error and the mailbox notification are reported as interrupts but never stop the queue.

All state is reached over a simple register bus. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr`, and every register update is visible the cycle after its edge.

Top module: `qerr_irq_ctrl`

## Requirements
- R1: After reset the cause bits, the enable bits, the queue run bit, continue-on-error and the mailbox data are all zero, and `irq` is low.
- R2: The cause bit positions are: bit 0 mailbox, bit 1 doorbell overflow, bit 2 instruction read error, bit 3 result write error, bit 4 engine software error. A hardware pulse sets its bit at that clock edge, and the bit stays set until software clears it.
- R3: A write to address 0 clears each cause bit whose write-data bit is 1. Zero bits leave their cause unchanged. A read of address 0 returns the cause bits in bits 4:0.
- R4: If a hardware pulse and a write-1-to-clear hit the same cause bit in the same cycle, the bit remains set.
- R5: A write to address 1 sets each cause bit whose write-data bit is 1. A read of address 1 returns the cause bits.
- R6: A write to address 2 sets the enable bits written as 1, and a write to address 3 clears them. Reads of either address return the current enables in bits 4:0.
- R7: `irq` is high exactly when some cause bit and its enable are both 1. It follows a register update in the cycle after that update's edge.
- R8: A write to address 5 stores the write data as the mailbox word and sets cause bit 0. A read of address 5 returns the stored word.
- R9: With continue-on-error at 0, a set of cause bit 1, 2 or 3 clears the queue run bit at that edge. The set can come from a hardware pulse or from the address 1 alias. It clears the bit even if the same cycle writes the run bit to 1.
- R10: Setting cause bit 0 or bit 4 never changes the queue run bit.
- R11: With continue-on-error at 1, no cause set changes the queue run bit.
- R12: Address 4 holds the queue run bit in bit 0 and continue-on-error in bit 1, both readable and writable. The run bit becomes 1 only through a software write; it never returns to 1 by itself.
- R13: Addresses 6 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_dbell_ovf | input | 1 | Doorbell overflow pulse |
| ev_inst_rd_err | input | 1 | Instruction read error pulse |
| ev_res_wr_err | input | 1 | Result write error pulse |
| ev_eng_swerr | input | 1 | Engine software error pulse |
| irq | output | 1 | Level interrupt |
| queue_en | output | 1 | Queue run bit |

## Verification
A cause bit latched wrongly shows up one cycle after its edge, either at `irq` when its enable is set or on reads of address 0 or 1. A flipped enable shows up in the same way at `irq` and at addresses 2 and 3. A wrong stop decision shows up on `queue_en` one cycle after the offending set. The bench probes the priority corners: a hardware set against a software clear, an auto-stop against a software restart in the same cycle, and a set with continue-on-error on. Each of these would otherwise go unnoticed until a later, unrelated event.

// File: rtl/qerr_pkg.sv
package qerr_pkg;

  localparam int unsigned NCAUSE = 5;
  localparam int unsigned ADDR_W = 3;

  // cause bit positions (software decodes them)
  localparam int unsigned CB_MBOX   = 0;
  localparam int unsigned CB_DBOVF  = 1;
  localparam int unsigned CB_INSTRD = 2;
  localparam int unsigned CB_RESWR  = 3;
  localparam int unsigned CB_SWERR  = 4;

  // causes that stop the queue when continue-on-error is off
  localparam logic [NCAUSE-1:0] STOP_MASK_DEF = 5'b01110;

  typedef enum logic [ADDR_W-1:0] {
    RA_CAUSE     = 3'd0,
    RA_CAUSE_SET = 3'd1,
    RA_MASK_SET  = 3'd2,
    RA_MASK_CLR  = 3'd3,
    RA_QCTL      = 3'd4,
    RA_MBOX      = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic cause_clr;
    logic cause_set;
    logic mask_set;
    logic mask_clr;
    logic qctl;
    logic mbox;
  } wr_stb_t;

  function automatic logic cause_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq_of(input logic [NCAUSE-1:0] cause,
                                  input logic [NCAUSE-1:0] ena);
    return |(cause & ena);
  endfunction

  function automatic logic stop_hit(input logic [NCAUSE-1:0] set_req,
                                    input logic [NCAUSE-1:0] mask,
                                    input logic cont);
    return !cont && (|(set_req & mask));
  endfunction

endpackage

// File: rtl/qerr_reg_decode.sv
module qerr_reg_decode
  import qerr_pkg::*;
(
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wr_stb_t           stb
);

  always_comb begin
    stb = '0;
    if (wr) begin
      unique case (addr)
        RA_CAUSE:     stb.cause_clr = 1'b1;
        RA_CAUSE_SET: stb.cause_set = 1'b1;
        RA_MASK_SET:  stb.mask_set  = 1'b1;
        RA_MASK_CLR:  stb.mask_clr  = 1'b1;
        RA_QCTL:      stb.qctl      = 1'b1;
        RA_MBOX:      stb.mbox      = 1'b1;
        default:      stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/qerr_cause_bank.sv
module qerr_cause_bank
  import qerr_pkg::*;
#(
  parameter int unsigned N = NCAUSE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] wbits,
  input  logic         sw_set_stb,
  input  logic         sw_clr_stb,
  input  logic         msk_set_stb,
  input  logic         msk_clr_stb,
  output logic [N-1:0] set_req,
  output logic [N-1:0] cause_q,
  output logic [N-1:0] ena_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic sw_clr_i;
    assign set_req[i] = hw_set[i] | (sw_set_stb & wbits[i]);
    assign sw_clr_i   = sw_clr_stb & wbits[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cause_q[i] <= 1'b0;
        ena_q[i]   <= 1'b0;
      end else begin
        cause_q[i] <= cause_next(cause_q[i], set_req[i], sw_clr_i);
        ena_q[i]   <= cause_next(ena_q[i], msk_set_stb & wbits[i],
                                 msk_clr_stb & wbits[i]);
      end
    end

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      set_req[i] |=> cause_q[i]); // R4
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q[i] && !sw_clr_i) |=> cause_q[i]); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_i && !set_req[i]) |=> !cause_q[i]); // R3
  end

endmodule

// File: rtl/qerr_qen_ctrl.sv
module qerr_qen_ctrl
  import qerr_pkg::*;
#(
  parameter int unsigned       N         = NCAUSE,
  parameter logic [N-1:0]      STOP_MASK = STOP_MASK_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic         qctl_stb,
  input  logic         wr_run,
  input  logic         wr_cont,
  output logic         stop_evt,
  output logic         qen_q,
  output logic         cont_q
);

  assign stop_evt = stop_hit(set_req, STOP_MASK, cont_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qen_q  <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      if (qctl_stb) cont_q <= wr_cont;
      if (stop_evt)      qen_q <= 1'b0;
      else if (qctl_stb) qen_q <= wr_run;
    end
  end

  AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !qen_q); // R9
  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!qen_q && !qctl_stb) |=> !qen_q); // R12
  AST_CONT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_q && !qctl_stb) |=> $stable(qen_q)); // R11

endmodule

// File: rtl/qerr_irq_ctrl.sv
module qerr_irq_ctrl
  import qerr_pkg::*;
#(
  parameter int unsigned  DATA_W    = 32,
  parameter logic [4:0]   STOP_MASK = STOP_MASK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_dbell_ovf,
  input  logic              ev_inst_rd_err,
  input  logic              ev_res_wr_err,
  input  logic              ev_eng_swerr,
  output logic              irq,
  output logic              queue_en
);

  wr_stb_t             stb;
  logic [NCAUSE-1:0]   hw_set;
  logic [NCAUSE-1:0]   set_req;
  logic [NCAUSE-1:0]   cause_q;
  logic [NCAUSE-1:0]   ena_q;
  logic                stop_evt;
  logic                cont_q;
  logic [DATA_W-1:0]   mbox_q;

  qerr_reg_decode u_dec (
    .wr   (reg_wr),
    .addr (reg_addr),
    .stb  (stb)
  );

  always_comb begin
    hw_set            = '0;
    hw_set[CB_MBOX]   = stb.mbox;
    hw_set[CB_DBOVF]  = ev_dbell_ovf;
    hw_set[CB_INSTRD] = ev_inst_rd_err;
    hw_set[CB_RESWR]  = ev_res_wr_err;
    hw_set[CB_SWERR]  = ev_eng_swerr;
  end

  qerr_cause_bank #(.N(NCAUSE)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_set      (hw_set),
    .wbits       (reg_wdata[NCAUSE-1:0]),
    .sw_set_stb  (stb.cause_set),
    .sw_clr_stb  (stb.cause_clr),
    .msk_set_stb (stb.mask_set),
    .msk_clr_stb (stb.mask_clr),
    .set_req     (set_req),
    .cause_q     (cause_q),
    .ena_q       (ena_q)
  );

  qerr_qen_ctrl #(.N(NCAUSE), .STOP_MASK(STOP_MASK)) u_qen (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (set_req),
    .qctl_stb (stb.qctl),
    .wr_run   (reg_wdata[0]),
    .wr_cont  (reg_wdata[1]),
    .stop_evt (stop_evt),
    .qen_q    (queue_en),
    .cont_q   (cont_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mbox_q <= '0;
    else if (stb.mbox) mbox_q <= reg_wdata;
  end

  assign irq = irq_of(cause_q, ena_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CAUSE, RA_CAUSE_SET: reg_rdata[NCAUSE-1:0] = cause_q;
      RA_MASK_SET, RA_MASK_CLR: reg_rdata[NCAUSE-1:0] = ena_q;
      RA_QCTL: reg_rdata[1:0] = {cont_q, queue_en};
      RA_MBOX: reg_rdata = mbox_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq); // R7
  AST_MBOX_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    stb.mbox |=> cause_q[CB_MBOX]); // R8

endmodule

// File: tb/qerr_irq_ctrl_bench.sv
module qerr_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_dbell_ovf = 1'b0, ev_inst_rd_err = 1'b0;
  logic        ev_res_wr_err = 1'b0, ev_eng_swerr = 1'b0;
  logic        irq, queue_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int          kq[$];
  logic [31:0] eq[$];
  string       rq[$];
  event        smp_ev;

  always #10 clk = ~clk; // 50 MHz

  qerr_irq_ctrl u_qerr_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_dbell_ovf(ev_dbell_ovf), .ev_inst_rd_err(ev_inst_rd_err),
    .ev_res_wr_err(ev_res_wr_err), .ev_eng_swerr(ev_eng_swerr),
    .irq(irq), .queue_en(queue_en)
  );

  // ev order: [3] engine sw err, [2] result write, [1] instr read, [0] doorbell ovf
  task automatic bus(input logic wr, input logic [2:0] a, input logic [31:0] d,
                     input logic [3:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    {ev_eng_swerr, ev_res_wr_err, ev_inst_rd_err, ev_dbell_ovf} = ev;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    {ev_eng_swerr, ev_res_wr_err, ev_inst_rd_err, ev_dbell_ovf} = '0;
  endtask

  task automatic push(input int k, input logic [31:0] e, input string r);
    kq.push_back(k); eq.push_back(e); rq.push_back(r);
    #1 -> smp_ev;
    #1;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    reg_addr = a;
    push(0, e, r);
  endtask

  task automatic expect_pin(input int k, input logic e, input string r);
    @(negedge clk);
    push(k, {31'd0, e}, r);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      int k; logic [31:0] e, obs; string r;
      @(smp_ev);
      while (kq.size() > 0) begin
        k = kq.pop_front(); e = eq.pop_front(); r = rq.pop_front();
        obs = (k == 0) ? reg_rdata : (k == 1) ? {31'd0, irq} : {31'd0, queue_en};
        checks++;
        if (obs !== e) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, obs, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) expect_rd(a[2:0], 32'h0, "R1");
    expect_pin(1, 1'b0, "R1 irq");
    expect_pin(2, 1'b0, "R1 queue_en");

    bus(1, 3'd4, 32'h1, 4'h0);
    expect_rd(3'd4, 32'h1, "R12 run written");

    bus(0, 3'd0, 32'h0, 4'b1000);
    expect_rd(3'd0, 32'h10, "R2 engine swerr bit4");
    expect_pin(2, 1'b1, "R10 swerr keeps run");
    bus(1, 3'd5, 32'hA5A5_0F0F, 4'h0);
    expect_rd(3'd0, 32'h11, "R8 mailbox bit0");
    expect_rd(3'd5, 32'hA5A5_0F0F, "R8 mailbox data");
    expect_pin(2, 1'b1, "R10 mailbox keeps run");
    expect_pin(1, 1'b0, "R7 no enables");

    bus(1, 3'd2, 32'h10, 4'h0);
    expect_rd(3'd2, 32'h10, "R6 set alias read");
    expect_rd(3'd3, 32'h10, "R6 clr alias read");
    expect_pin(1, 1'b1, "R7 irq on");
    bus(1, 3'd3, 32'h10, 4'h0);
    expect_rd(3'd2, 32'h0, "R6 cleared");
    expect_pin(1, 1'b0, "R7 irq off");

    bus(1, 3'd0, 32'h01, 4'h0);
    expect_rd(3'd0, 32'h10, "R3 w1c");
    bus(1, 3'd0, 32'h00, 4'h0);
    expect_rd(3'd0, 32'h10, "R3 zero write");

    bus(0, 3'd0, 32'h0, 4'b0001);
    expect_rd(3'd0, 32'h12, "R2 doorbell bit1");
    expect_pin(2, 1'b0, "R9 hw stop");
    expect_rd(3'd4, 32'h0, "R9 qctl read");

    bus(1, 3'd4, 32'h1, 4'h0);
    repeat (3) @(posedge clk);
    expect_pin(2, 1'b1, "R12 restart holds");
    bus(1, 3'd1, 32'h08, 4'h0);
    expect_rd(3'd1, 32'h1A, "R5 set alias");
    expect_pin(2, 1'b0, "R9 sw set stop");

    bus(1, 3'd4, 32'h1, 4'b0010);
    expect_rd(3'd0, 32'h1E, "R2 instr read bit2");
    expect_pin(2, 1'b0, "R9 stop beats restart");

    bus(1, 3'd4, 32'h3, 4'h0);
    bus(1, 3'd0, 32'h08, 4'h0);
    expect_rd(3'd0, 32'h16, "R3 clear bit3");
    bus(0, 3'd0, 32'h0, 4'b0100);
    expect_rd(3'd0, 32'h1E, "R2 result write bit3");
    expect_pin(2, 1'b1, "R11 continue on error");

    bus(1, 3'd0, 32'h02, 4'b0001);
    expect_rd(3'd0, 32'h1E, "R4 set beats clear");
    expect_pin(2, 1'b1, "R11 still running");

    bus(1, 3'd6, 32'hFFFF_FFFF, 4'h0);
    bus(1, 3'd7, 32'hFFFF_FFFF, 4'h0);
    expect_rd(3'd6, 32'h0, "R13 addr6 reads 0");
    expect_rd(3'd7, 32'h0, "R13 addr7 reads 0");
    expect_rd(3'd0, 32'h1E, "R13 cause untouched");
    expect_rd(3'd2, 32'h0, "R13 enables untouched");
    expect_rd(3'd4, 32'h3, "R13 qctl untouched");

    bus(1, 3'd2, 32'h02, 4'h0);
    expect_pin(1, 1'b1, "R7 bit1 enabled");
    bus(1, 3'd4, 32'h0, 4'h0);
    repeat (5) @(posedge clk);
    expect_pin(2, 1'b0, "R12 no self restart");
    expect_rd(3'd4, 32'h0, "R12 qctl zero");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule